// File: doc/BRIEF.md
# Multi-FIFO Trigger Readout Controller

This controller empties event data from four parallel sample FIFOs into a downstream data sink, handling one trigger at a time. Triggers that pass the almost-full filter are forwarded to the front end. They also raise a saturating pending-trigger count. While that count is non-zero, the controller visits FIFO 0, 1, 2 and 3 in turn. From each FIFO it takes a fixed block of words, and the count drops by one once the last FIFO's block is complete.

A read request is issued only in a cycle where the sink is ready and the selected FIFO holds data. A sink write enable follows every controller read by one clock, which matches a FIFO with one cycle of read latency. A microcontroller can claim the FIFO select and read request lines through an active-low ownership input. While it owns them, the sequencer sits idle and its position is cleared.

Top module: `trig_readout`

## Requirements
- R1: `pending` is 4 bits wide. It rises by one for each forwarded trigger and saturates at 15. It falls by one when an event completes.
- R2: In each visit, the controller issues exactly 96 read requests (`BLOCK_WORDS`) to the selected FIFO, then moves to the next FIFO.
- R3: FIFOs are visited in the order 0, 1, 2, 3 on `fifo_sel`. `pending` decrements only on the last read of FIFO 3, and the select then returns to 0.
- R4: No controller read request is issued while `sink_ready` is 0. Reading resumes when `sink_ready` returns to 1.
- R5: No controller read request is issued while the FIFO on `fifo_sel` reports empty (`fifo_empty[fifo_sel]` = 1).
- R6: While `mcu_own_n` is 0, `fifo_sel` equals `mcu_sel` and `fifo_rd` equals `mcu_rd`. During that time `sink_we` stays 0, and the FIFO index and word position are cleared. Controller reads may start from the second cycle after `mcu_own_n` returns to 1.
- R7: After reset, `pending` is 0, the index is 0, and `fifo_rd` and `sink_we` are 0.
- R8: `fe_trig` is `trig_in` gated by `fifo_afull`. A trigger that arrives while `fifo_afull` is 1 is neither forwarded nor counted.
- R9: `sink_we` is 1 exactly in the cycle after each controller read request.
- R10: If a trigger is counted in the same cycle that an event completes, `pending` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Decoded trigger pulse |
| fifo_afull | input | 1 | Almost-full flag of the sample FIFOs |
| fe_trig | output | 1 | Trigger forwarded to the front end |
| sink_ready | input | 1 | Sink can accept a word |
| fifo_empty | input | 4 | Per-FIFO empty flags |
| mcu_own_n | input | 1 | 0: microcontroller owns select and read |
| mcu_sel | input | 2 | Microcontroller FIFO select |
| mcu_rd | input | 1 | Microcontroller read request |
| fifo_sel | output | 2 | FIFO select |
| fifo_rd | output | 1 | FIFO read request |
| sink_we | output | 1 | Write enable toward the sink |
| pending | output | 4 | Pending-trigger count |

## Verification
The assertions assume that `fifo_empty` and `sink_ready` are settled before each clock edge. They also assume that `mcu_own_n` is a level held for many cycles, not toggled between clocks. The bench drives every input shortly after a rising edge and holds it for the full cycle. It changes ownership only through whole-cycle phases. Triggers are issued as single-cycle pulses, and the almost-full flag is sometimes raised during a trigger so that the blocking path is exercised as well.

// File: rtl/trig_readout.sv
module trig_readout #(
  parameter int NFIFO       = 4,
  parameter int BLOCK_WORDS = 96,
  parameter int CNT_W       = 4,
  localparam int SEL_W      = $clog2(NFIFO),
  localparam int WRD_W      = $clog2(BLOCK_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             fifo_afull,
  output logic             fe_trig,
  input  logic             sink_ready,
  input  logic [NFIFO-1:0] fifo_empty,
  input  logic             mcu_own_n,
  input  logic [SEL_W-1:0] mcu_sel,
  input  logic             mcu_rd,
  output logic [SEL_W-1:0] fifo_sel,
  output logic             fifo_rd,
  output logic             sink_we,
  output logic [CNT_W-1:0] pending
);

  localparam logic [SEL_W-1:0] LAST_IDX  = SEL_W'(NFIFO - 1);
  localparam logic [WRD_W-1:0] LAST_WORD = WRD_W'(BLOCK_WORDS - 1);

  logic             run_q;
  logic [SEL_W-1:0] idx_q;
  logic [WRD_W-1:0] word_q;
  logic [CNT_W-1:0] pend_q;
  logic             we_q;

  logic ctrl_rd, blk_end, evt_end;

  assign fe_trig  = trig_in & ~fifo_afull;
  assign ctrl_rd  = run_q & mcu_own_n & (pend_q != '0) & sink_ready & ~fifo_empty[idx_q];
  assign blk_end  = ctrl_rd & (word_q == LAST_WORD);
  assign evt_end  = blk_end & (idx_q == LAST_IDX);

  assign fifo_sel = mcu_own_n ? idx_q : mcu_sel;
  assign fifo_rd  = mcu_own_n ? ctrl_rd : mcu_rd;
  assign sink_we  = we_q;
  assign pending  = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      run_q <= mcu_own_n;
      we_q  <= ctrl_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      word_q <= '0;
    end else if (!mcu_own_n) begin
      idx_q  <= '0;
      word_q <= '0;
    end else if (ctrl_rd) begin
      if (blk_end) begin
        word_q <= '0;
        idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end else begin
        word_q <= word_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      case ({fe_trig, evt_end})
        2'b10:   if (pend_q != '1) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  p_sat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '1) |=> (pending != '0));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == $past(pending)) || (pending == $past(pending) + 1'b1) ||
    (pending == $past(pending) - 1'b1));

  p_dec_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending < $past(pending)) |-> ($past(fifo_sel) == LAST_IDX && $past(fifo_rd) && $past(mcu_own_n)));

  p_rd_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_own_n && fifo_rd) |-> sink_ready);

  p_rd_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_own_n && fifo_rd) |-> !fifo_empty[fifo_sel]);

  p_bypass_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mcu_own_n |=> !sink_we);

  p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_afull || !trig_in) |=> (pending <= $past(pending)));

  p_we_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_own_n && fifo_rd) |=> sink_we);

  p_we_only_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mcu_own_n && fifo_rd) |=> !sink_we);

endmodule

// File: tb/sim_trig_readout.sv
module sim_trig_readout;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 0, fifo_afull = 0, sink_ready = 0, mcu_own_n = 0, mcu_rd = 0;
  logic [3:0] fifo_empty = 4'hF;
  logic [1:0] mcu_sel = 0;
  logic fe_trig, fifo_rd, sink_we;
  logic [1:0] fifo_sel;
  logic [3:0] pending;

  int checks = 0, fails = 0, cycles = 0;
  bit mon_on = 0, done = 0;

  trig_readout u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_run, m_idx, m_word, m_pend, m_we;
  int e_rd;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_idx = 0; m_word = 0; m_pend = 0; m_we = 0;
    end else begin
      int fwd, fin;
      e_rd = (m_run && mcu_own_n && m_pend > 0 && sink_ready && !fifo_empty[m_idx]) ? 1 : 0;
      fwd = (trig_in && !fifo_afull) ? 1 : 0;
      fin = (e_rd && m_word == WORDS-1 && m_idx == 3) ? 1 : 0;
      if (fwd && !fin && m_pend < 15) m_pend++;
      else if (fin && !fwd) m_pend--;
      m_we = e_rd;
      if (!mcu_own_n) begin m_idx = 0; m_word = 0; end
      else if (e_rd) begin
        if (m_word == WORDS-1) begin m_word = 0; m_idx = (m_idx + 1) % 4; end
        else m_word++;
      end
      m_run = mcu_own_n ? 1 : 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      int xr, xs;
      xr = mcu_own_n ? ((m_run && m_pend > 0 && sink_ready && !fifo_empty[m_idx]) ? 1 : 0) : int'(mcu_rd);
      xs = mcu_own_n ? m_idx : int'(mcu_sel);
      chk("R1 pending", int'(pending), m_pend);
      chk("R3 fifo_sel", int'(fifo_sel), xs);
      chk("R4 fifo_rd", int'(fifo_rd), xr);
      chk("R9 sink_we", int'(sink_we), m_we);
      chk("R8 fe_trig", int'(fe_trig), int'(trig_in && !fifo_afull));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_trig(input logic af);
    trig_in = 1; fifo_afull = af; tick();
    trig_in = 0; fifo_afull = 0;
  endtask

  int per_sel[4];

  initial begin
    tick(3);
    @(negedge clk);
    chk("R7 reset pending", int'(pending), 0);
    chk("R7 reset rd", int'(fifo_rd), 0);
    chk("R7 reset we", int'(sink_we), 0);
    @(posedge clk); #1;
    rst_n = 1; mon_on = 1;
    tick();

    // microcontroller ownership
    mcu_sel = 2; mcu_rd = 1; sink_ready = 1; fifo_empty = 0;
    @(negedge clk);
    chk("R6 bypass sel", int'(fifo_sel), 2);
    chk("R6 bypass rd", int'(fifo_rd), 1);
    tick();
    @(negedge clk);
    chk("R6 bypass we", int'(sink_we), 0);
    mcu_rd = 0;
    tick();

    // saturation and blocking while owned
    for (int i = 0; i < 18; i++) pulse_trig(1'b0);
    @(negedge clk);
    chk("R1 saturated", int'(pending), 15);
    tick(); trig_in = 1; fifo_afull = 1;
    @(negedge clk);
    chk("R8 blocked fwd", int'(fe_trig), 0);
    tick(); trig_in = 0; fifo_afull = 0;
    @(negedge clk);
    chk("R8 blocked count", int'(pending), 15);

    // reset to clear, then one clean event
    @(posedge clk); #1; rst_n = 0; tick(); rst_n = 1; tick();
    pulse_trig(1'b0);
    mcu_own_n = 1; sink_ready = 1; fifo_empty = 0;
    for (int s = 0; s < 4; s++) per_sel[s] = 0;
    for (int i = 0; i < 500 && pending != 0; i++) begin
      @(negedge clk);
      if (fifo_rd) per_sel[fifo_sel]++;
    end
    for (int s = 0; s < 4; s++) chk("R2 block size", per_sel[s], WORDS);
    tick();
    @(negedge clk);
    chk("R3 drained", int'(pending), 0);
    chk("R3 sel wrapped", int'(fifo_sel), 0);

    // ready and empty stalls
    tick(); pulse_trig(1'b0);
    sink_ready = 0;
    @(negedge clk);
    chk("R4 stall ready", int'(fifo_rd), 0);
    tick(); sink_ready = 1; fifo_empty = 4'b0001;
    @(negedge clk);
    chk("R5 stall empty", int'(fifo_rd), 0);
    tick(); fifo_empty = 0;
    @(negedge clk);
    chk("R4 resume", int'(fifo_rd), 1);

    // simultaneous trigger and event completion
    begin
      int cnt = 1;
      while (cnt < 383) begin
        @(negedge clk);
        if (fifo_rd) cnt++;
      end
    end
    @(posedge clk); #1; fifo_empty = 4'hF;
    tick();
    @(negedge clk);
    chk("R3 at last fifo", int'(fifo_sel), 3);
    chk("R10 pre pending", int'(pending), 1);
    @(posedge clk); #1; fifo_empty = 0; trig_in = 1;
    @(negedge clk);
    chk("R3 final read", int'(fifo_rd), 1);
    tick(); trig_in = 0;
    @(negedge clk);
    chk("R10 inc and dec", int'(pending), 1);

    // irregular traffic, model compares every cycle
    for (int i = 0; i < 6000; i++) begin
      sink_ready = (i % 7) != 3;
      fifo_empty = 4'((i * 5) % 11 == 0 ? (1 << (i % 4)) : 0);
      trig_in = (i % 45) == 0;
      fifo_afull = (i % 135) == 90;
      mcu_own_n = !((i % 2000) >= 1500 && (i % 2000) < 1520);
      mcu_sel = 2'(i); mcu_rd = i[0];
      tick();
    end
    trig_in = 0; mcu_own_n = 0;
    tick();
    @(negedge clk);
    chk("R6 owned idle we", int'(sink_we), 0);
    mcu_own_n = 1; fifo_empty = 0; sink_ready = 1;
    @(negedge clk);
    chk("R6 release sel", int'(fifo_sel), 0);
    tick(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule